// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary32 operands and returns one binary32 product, rounded to nearest with ties to even. Four flags come with the product: overflow, underflow, invalid and inexact. The stored exponents are added and one bias is removed. The two 24-bit significands, each with its hidden one restored, are multiplied to a 48-bit product. That product is normalized by at most one right shift. Guard, round and sticky bits are taken from the discarded low half and used to round it.

Subnormal numbers are not supported. An operand with a zero exponent field counts as a signed zero, whatever its fraction. A result whose biased exponent would fall to zero or below is returned as a signed zero. Infinities and NaNs follow the usual special-value rules, and every NaN result is the single quiet pattern 0x7FC00000.

The block is a two-stage pipeline. An operand pair presented with `in_valid` high on one clock edge appears on the outputs, with `out_valid` high, after the second edge that follows. It accepts a new pair on every cycle.

Top module: `fpm_mul`

## Requirements
- R1: `out_valid` is high after an edge exactly when `in_valid` was high two edges earlier. Back-to-back pairs each produce their own result, in order, one per cycle.
- R2: While `rst_n` is low at a clock edge, `out_valid`, `product` and all four flags are cleared to zero.
- R3: For two normal operands, the sign is the XOR of the operand signs and the biased exponent is ea+eb-127. The significand is the product of the 24-bit significands with hidden ones. When that product is 2 or more it is shifted right by one and the exponent is incremented.
- R4: Rounding is to nearest, ties to even, using guard, round and sticky bits. Sticky is the OR of every product bit below the round bit. `flag_inexact` (bit 0 of the bench flag nibble) is set when any discarded bit is nonzero.
- R5: A rounding increment that carries out of the 23-bit fraction sets the fraction to zero and adds one to the exponent. The range checks of R6 and R7 apply to this final exponent.
- R6: A final biased exponent of 255 or more gives an infinity with the computed sign and raises `flag_overflow` and `flag_inexact`.
- R7: A final biased exponent of 0 or less gives a zero with the computed sign and raises `flag_underflow` and `flag_inexact`.
- R8: An operand with exponent field 0 is treated as zero, whatever its fraction. Zero times a finite value gives a zero with the XOR sign and raises no flag.
- R9: Infinity times a nonzero finite value, or times infinity, gives an infinity with the XOR sign and raises no flag.
- R10: Zero times infinity gives 0x7FC00000 and raises `flag_invalid` only.
- R11: If either operand is a NaN (exponent 255, fraction nonzero), the product is 0x7FC00000 with no flag raised. This takes precedence over R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result present this cycle |
| product | output | 32 | Rounded binary32 product |
| flag_overflow | output | 1 | Result overflowed to infinity |
| flag_underflow | output | 1 | Result flushed to zero |
| flag_invalid | output | 1 | Zero times infinity |
| flag_inexact | output | 1 | Result differs from the exact product |

## Verification
Exact products such as 1.5 by 1.5 are tried both below and above 2, which checks whether the normalizing shift is applied. Operand pairs with a few low fraction bits set place the discarded bits in specific positions. These patterns separate a round-up above the halfway point, a tie resolved toward an odd or an even last bit, and a sticky-only remainder. Fractions of nearly all ones drive the rounding carry into the exponent, at the top of the range (creating overflow) and at the bottom (rescuing a would-be underflow). Special operands — zero, subnormal, infinity and NaN, in each pairing and with both signs — show that the special cases are selected in the right priority order. The table is streamed on consecutive cycles to check the pipeline.

// File: rtl/fpm_pkg.sv
// Package: shared widths and types of the binary32 multiplier.
// Assumes: binary32 field layout (sign, exponent, fraction, MSB first).
package fpm_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;           // with hidden one
    localparam int PROD_W = 2 * SIG_W;
    localparam int EXT_W  = EXP_W + 2;            // signed working exponent
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              is_zero;
        logic              is_inf;
        logic              is_nan;
    } fpm_op_t;

    typedef enum logic [2:0] {
        K_NORM, K_ZERO, K_INF, K_NAN, K_INVALID
    } fpm_kind_e;
endpackage

// File: rtl/fpm_unpack.sv
// Module: splits one binary32 word into fields and classes it.
// Assumes: subnormals are flushed, so a zero exponent means zero.
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fpm_op_t           op
);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;

    assign e = word[WORD_W-2 -: EXP_W];
    assign f = word[FRAC_W-1:0];

    // Field split and class decode.
    always_comb begin
        op.sign    = word[WORD_W-1];
        op.exp     = e;
        op.sig     = {1'b1, f};
        op.is_zero = (e == '0);
        op.is_inf  = (e == '1) && (f == '0);
        op.is_nan  = (e == '1) && (f != '0);
    end
endmodule

// File: rtl/fpm_round.sv
// Module: normalizes the raw significand product, rounds to nearest even
// and packs the result word and flags for every operand class.
// Assumes: prod lies in [1,4) in units of 2^(2*FRAC_W) for K_NORM.
module fpm_round
    import fpm_pkg::*;
(
    input  logic                    sign,
    input  logic signed [EXT_W-1:0] exp_sum,
    input  logic [PROD_W-1:0]       prod,
    input  fpm_kind_e               kind,
    output logic [WORD_W-1:0]       result,
    output logic                    ovf,
    output logic                    unf,
    output logic                    inv,
    output logic                    inx
);
    logic                    top;
    logic [FRAC_W-1:0]       frac_raw;
    logic                    g_bit, r_bit, s_bit, up;
    logic [FRAC_W:0]         frac_rnd;
    logic signed [EXT_W-1:0] exp_n, exp_f;

    // Normalize by one position when the product reached 2.
    always_comb begin
        top = prod[PROD_W-1];
        if (top) begin
            frac_raw = prod[PROD_W-2 -: FRAC_W];
            g_bit    = prod[FRAC_W];
            r_bit    = prod[FRAC_W-1];
            s_bit    = |prod[FRAC_W-2:0];
        end else begin
            frac_raw = prod[PROD_W-3 -: FRAC_W];
            g_bit    = prod[FRAC_W-1];
            r_bit    = prod[FRAC_W-2];
            s_bit    = |prod[FRAC_W-3:0];
        end
        exp_n = exp_sum + EXT_W'(top);
    end

    // Round to nearest, ties to even; a carry bumps the exponent.
    always_comb begin
        up       = g_bit & (r_bit | s_bit | frac_raw[0]);
        frac_rnd = {1'b0, frac_raw} + (FRAC_W+1)'(up);
        exp_f    = exp_n + EXT_W'(frac_rnd[FRAC_W]);
    end

    // Select the packed word and flags from the operand class.
    always_comb begin
        result = '0;
        ovf = 1'b0; unf = 1'b0; inv = 1'b0; inx = 1'b0;
        unique case (kind)
            K_NAN:     result = QNAN;
            K_INVALID: begin result = QNAN; inv = 1'b1; end
            K_INF:     result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            K_ZERO:    result = {sign, {(WORD_W-1){1'b0}}};
            default: begin
                if (exp_f >= EXT_W'(EXP_MAX)) begin
                    result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    ovf = 1'b1; inx = 1'b1;
                end else if (exp_f <= 0) begin
                    result = {sign, {(WORD_W-1){1'b0}}};
                    unf = 1'b1; inx = 1'b1;
                end else begin
                    result = {sign, exp_f[EXP_W-1:0], frac_rnd[FRAC_W-1:0]};
                    inx = g_bit | r_bit | s_bit;
                end
            end
        endcase
    end
endmodule

// File: rtl/fpm_mul.sv
// Module: two-stage binary32 multiplier. Stage 1 classes the operands,
// adds exponents and multiplies significands; stage 2 rounds and packs.
// Assumes: one pair per cycle at most; no back-pressure.
module fpm_mul
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] product,
    output logic              flag_overflow,
    output logic              flag_underflow,
    output logic              flag_invalid,
    output logic              flag_inexact
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] words [N_OPS];
    fpm_op_t           ops   [N_OPS];
    fpm_kind_e         kind_c;

    assign words[0] = op_a;
    assign words[1] = op_b;

    genvar gi;
    generate
        for (gi = 0; gi < N_OPS; gi++) begin : g_unpack
            fpm_unpack u_unp (.word(words[gi]), .op(ops[gi]));
        end
    endgenerate

    // Class priority: NaN, zero-times-infinity, infinity, zero, normal.
    always_comb begin
        if (ops[0].is_nan || ops[1].is_nan)
            kind_c = K_NAN;
        else if ((ops[0].is_inf && ops[1].is_zero) || (ops[0].is_zero && ops[1].is_inf))
            kind_c = K_INVALID;
        else if (ops[0].is_inf || ops[1].is_inf)
            kind_c = K_INF;
        else if (ops[0].is_zero || ops[1].is_zero)
            kind_c = K_ZERO;
        else
            kind_c = K_NORM;
    end

    logic                    s1_valid, s1_sign;
    logic signed [EXT_W-1:0] s1_exp;
    logic [PROD_W-1:0]       s1_prod;
    fpm_kind_e               s1_kind;

    // Stage 1 register: exponent sum minus one bias and raw significand product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_exp   <= '0;
            s1_prod  <= '0;
            s1_kind  <= K_ZERO;
        end else begin
            s1_valid <= in_valid;
            s1_sign  <= ops[0].sign ^ ops[1].sign;
            s1_exp   <= $signed({2'b00, ops[0].exp}) + $signed({2'b00, ops[1].exp})
                        - EXT_W'(BIAS);
            s1_prod  <= {{SIG_W{1'b0}}, ops[0].sig} * {{SIG_W{1'b0}}, ops[1].sig};
            s1_kind  <= kind_c;
        end
    end

    logic [WORD_W-1:0] r_word;
    logic              r_ovf, r_unf, r_inv, r_inx;

    fpm_round u_round (
        .sign(s1_sign), .exp_sum(s1_exp), .prod(s1_prod), .kind(s1_kind),
        .result(r_word), .ovf(r_ovf), .unf(r_unf), .inv(r_inv), .inx(r_inx)
    );

    // Stage 2 register: rounded word and flags to the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            product        <= '0;
            flag_overflow  <= 1'b0;
            flag_underflow <= 1'b0;
            flag_invalid   <= 1'b0;
            flag_inexact   <= 1'b0;
        end else begin
            out_valid      <= s1_valid;
            product        <= r_word;
            flag_overflow  <= r_ovf;
            flag_underflow <= r_unf;
            flag_invalid   <= r_inv;
            flag_inexact   <= r_inx;
        end
    end

    logic [EXP_W-1:0]  p_exp;
    logic [FRAC_W-1:0] p_frac;
    assign p_exp  = product[WORD_W-2 -: EXP_W];
    assign p_frac = product[FRAC_W-1:0];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)) else $error("valid latency"); // R1
    AST_VALID_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(rst_n, 1) && $past(rst_n, 2)) |-> out_valid)
        else $error("valid dropped"); // R1
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(p_exp == '1 && p_frac != '0))
        |-> product[WORD_W-1] == ($past(op_a[WORD_W-1], 2) ^ $past(op_b[WORD_W-1], 2)))
        else $error("sign"); // R3
    AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(p_exp == '0 && p_frac != '0)) else $error("subnormal out"); // R7
    AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> (p_exp == '1 && p_frac == '0 && flag_inexact))
        else $error("overflow word"); // R6
    AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> (product[WORD_W-2:0] == '0 && flag_inexact))
        else $error("underflow word"); // R7
    AST_INV_IS_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (product == QNAN && !flag_inexact)) else $error("invalid word"); // R10
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p_exp == '1 && p_frac != '0) |-> product == QNAN)
        else $error("nan word"); // R11
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_overflow, flag_underflow, flag_invalid})) else $error("flags"); // R6
endmodule

// File: tb/sim_fpm_mul.sv
module sim_fpm_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        out_valid;
    logic [31:0] product;
    logic        flag_overflow, flag_underflow, flag_invalid, flag_inexact;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fpm_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .product(product), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_invalid(flag_invalid),
        .flag_inexact(flag_inexact)
    );

    // flag nibble: {overflow, underflow, invalid, inexact}
    localparam int NV = 28;
    localparam logic [31:0] VA [NV] = '{
        32'h3F800000, 32'h3FC00000, 32'hBFC00000, 32'h3F000000,
        32'h3F800001, 32'h3F800001, 32'h3F800003, 32'h3FC00001,
        32'h3FFFFFFE, 32'h7F000000, 32'hFF000000, 32'h7F7FFFFE,
        32'h00800000, 32'h80800000, 32'h00800000, 32'h00FFFFFE,
        32'h00400000, 32'h80000001, 32'h00000000, 32'h7F800000,
        32'hFF800000, 32'h80000000, 32'h00000001, 32'h7FC00001,
        32'hFF800001, 32'h7F800000, 32'h3FFFFFFF, 32'h3FC00000};
    localparam logic [31:0] VB [NV] = '{
        32'h3F800000, 32'h3FC00000, 32'h40000000, 32'hBEE00000,
        32'h3F800001, 32'h3FC00000, 32'h3FC00000, 32'h3FC00000,
        32'h3F800001, 32'h40000000, 32'h7F000000, 32'h3F800001,
        32'h3F000000, 32'h3F000000, 32'h3F800000, 32'h3F000001,
        32'h3F800000, 32'h40000000, 32'hC0000000, 32'hC0000000,
        32'hFF800000, 32'h7F800000, 32'hFF800000, 32'h3F800000,
        32'h00000000, 32'h7FFFFFFF, 32'h3FFFFFFF, 32'h3FAAAAAA};
    localparam logic [31:0] VR [NV] = '{
        32'h3F800000, 32'h40100000, 32'hC0400000, 32'hBE600000,
        32'h3F800002, 32'h3FC00002, 32'h3FC00004, 32'h40100001,
        32'h40000000, 32'h7F800000, 32'hFF800000, 32'h7F800000,
        32'h00000000, 32'h80000000, 32'h00800000, 32'h00800000,
        32'h00000000, 32'h80000000, 32'h80000000, 32'hFF800000,
        32'h7F800000, 32'h7FC00000, 32'h7FC00000, 32'h7FC00000,
        32'h7FC00000, 32'h7FC00000, 32'h407FFFFE, 32'h3FFFFFFF};
    localparam logic [3:0] VF [NV] = '{
        4'h0, 4'h0, 4'h0, 4'h0,
        4'h1, 4'h1, 4'h1, 4'h1,
        4'h1, 4'h9, 4'h9, 4'h9,
        4'h5, 4'h5, 4'h0, 4'h1,
        4'h0, 4'h0, 4'h0, 4'h0,
        4'h0, 4'h2, 4'h2, 4'h0,
        4'h0, 4'h0, 4'h1, 4'h0};
    localparam string VT [NV] = '{
        "R3 one", "R3 norm shift", "R3 sign", "R3 mixed",
        "R4 sticky only", "R4 tie odd up", "R4 tie even down", "R4 shifted round",
        "R5 carry", "R6 overflow", "R6 neg overflow", "R5 R6 carry overflow",
        "R7 underflow", "R7 neg underflow", "R7 min normal", "R5 R7 carry rescue",
        "R8 subnormal", "R8 neg subnormal", "R8 zero", "R9 inf finite",
        "R9 inf inf", "R10 zero inf", "R10 subnormal inf", "R11 nan",
        "R11 nan zero", "R11 inf nan", "R4 R3 near four", "R3 exact max frac"};

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] outs();
        return {flag_overflow, flag_underflow, flag_invalid, flag_inexact, product};
    endfunction

    // Watchdog: ends a hung run as a failure.
    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R2: reset holds outputs low even with traffic on the inputs.
        in_valid = 1'b1; op_a = 32'h3FC00000; op_b = 32'h3FC00000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R2 reset valid", {35'd0, out_valid}, 36'd0);
        check("R2 reset outputs", outs(), 36'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 idle valid", {35'd0, out_valid}, 36'd0);

        // Streamed table, one pair per cycle (R1 back-to-back).
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                check({VT[i-2], " R1 valid"}, {35'd0, out_valid}, 36'd1);
                check(VT[i-2], outs(), {VF[i-2], VR[i-2]});
            end
            if (i < NV) begin
                in_valid = 1'b1; op_a = VA[i]; op_b = VB[i];
            end else begin
                in_valid = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        check("R1 drain valid", {35'd0, out_valid}, 36'd0);

        // R1: a single pair with gaps arrives exactly two edges later.
        in_valid = 1'b1; op_a = 32'h40400000; op_b = 32'hC0400000;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check("R1 one edge", {35'd0, out_valid}, 36'd0);
        @(posedge clk); @(negedge clk);
        check("R1 two edges valid", {35'd0, out_valid}, 36'd1);
        check("R3 minus nine", outs(), {4'h0, 32'hC1100000});
        @(posedge clk); @(negedge clk);
        check("R1 after gap", {35'd0, out_valid}, 36'd0);

        // R2: reset in mid-stream clears the pipeline.
        in_valid = 1'b1; op_a = 32'h7F000000; op_b = 32'h7F000000;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 mid reset", outs(), 36'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2 flushed valid", {35'd0, out_valid}, 36'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule